// File: doc/BRIEF.md
# Playback Audio FIFO Register Front-End

This block sits between a processor bus and an audio serializer in a transmit-only audio path. Software reaches it through a small word-addressed register window. It programs an operating configuration, selects which events may interrupt, and pushes 32-bit sample words into a transmit FIFO. The serializer takes words from the FIFO head through a pop strobe. It also receives the transmit enable, the clock ratio and the sample resolution fields taken from the configuration word.

The block watches the FIFO fill. It reports two conditions: "running low" when the fill is below a threshold, and "starved" when the FIFO is empty. The threshold is the FIFO depth shifted right by a 4-bit level code, so every step of the code halves it. Each condition latches into a status bit that software clears by writing 1. A bit whose condition still holds sets again on the next clock. A single interrupt line combines the status bits under a mask and a global interrupt enable.

Top module: `audio_txfifo_regs`

## Requirements
- R1: While reset is held, the configuration, mask and status registers read 0, the FIFO reports empty and the interrupt line is low.
- R2: Word 0 reads the VERSION parameter and ignores writes. Word 1 stores and returns all 32 configuration bits. Word 2 returns only mask bits [1:0]. Words 4 to 7 read as 0.
- R3: A write to word 4 appends the written word to the FIFO. Words leave on fifo_pop in write order, and the head is always visible on fifo_rd_data.
- R4: A write to word 4 while the FIFO holds DEPTH words is dropped, and the stored contents and fill are unchanged.
- R5: Writes to words 5, 6 and 7 do not change the FIFO.
- R6: Status bit 1 (level) is set when the fill is below DEPTH >> c. Here c is configuration bits [27:24], and a code of 0 counts as 1.
- R7: Status bit 0 (underrun) is set when the FIFO is empty.
- R8: Writing word 3 clears each status bit whose write-data bit is 1. A cleared bit that still has its condition reads 1 again on the following cycle. One without its condition stays 0.
- R9: irq is high exactly when configuration bit 1 is 1 and (status AND mask) is nonzero.
- R10: tx_enable follows configuration bit 0, clk_ratio follows bits [15:8], and sample_res follows bits [21:16].
- R11: A fifo_pop while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_word_addr | input | 3 | Register word index (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word_addr, combinational |
| fifo_pop | input | 1 | Serializer takes the head word |
| fifo_rd_data | output | 32 | Current head word |
| fifo_empty | output | 1 | FIFO holds no words |
| tx_enable | output | 1 | Transmit enable field |
| clk_ratio | output | 8 | Clock ratio field |
| sample_res | output | 6 | Sample resolution field |
| irq | output | 1 | Interrupt request |

## Verification
The fill counter is the one internal state that all the status logic depends on. If the counter drifts from the true number of stored words, the problem first appears on fifo_empty. It also appears in the status word read one cycle after a clear, because that read then equals exactly the current conditions. The bench clears status after each operation and compares that read against a reference queue. A wrong pointer or a dropped push therefore shows up at the very next pop as a head word that does not match. A bad threshold shift shows up in the first level check after the fill crosses the boundary.

// File: rtl/afe_pkg.sv
`timescale 1ns/1ps
// Package: shared register word indices and the configuration word layout.
// Assumes a 32-bit register bus addressed by word.
package afe_pkg;
    localparam logic [2:0] W_VERSION = 3'd0;
    localparam logic [2:0] W_CONFIG  = 3'd1;
    localparam logic [2:0] W_MASK    = 3'd2;
    localparam logic [2:0] W_STATUS  = 3'd3;
    localparam logic [2:0] W_PUSH    = 3'd4;

    localparam int ST_UNDER = 0;
    localparam int ST_LEVEL = 1;

    typedef struct packed {
        logic [3:0] chan_sel;
        logic [3:0] level_code;
        logic [1:0] rsv_hi;
        logic [5:0] res;
        logic [7:0] ratio;
        logic [4:0] rsv_lo;
        logic       left_first;
        logic       int_en;
        logic       tx_en;
    } cfg_word_t;
endpackage

// File: rtl/afe_tx_fifo.sv
`timescale 1ns/1ps
// Module: transmit FIFO with a fill counter and a first-word-fall-through head.
// Assumes DEPTH is a power of two. A push while full and a pop while empty are ignored.
module afe_tx_fifo #(
    parameter int DEPTH = 2048,
    parameter int W     = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // Storage write, no reset needed for data.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and fill bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
    a_r11_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/afe_level_thresh.sv
`timescale 1ns/1ps
// Module: compares the fill against DEPTH shifted right by the level code.
// Assumes code 0 behaves as code 1. Purely combinational.
module afe_level_thresh #(
    parameter int DEPTH = 2048,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic [3:0]       level_code,
    input  logic [CNT_W-1:0] count,
    output logic             below
);
    logic [3:0]       shift;
    logic [CNT_W-1:0] thresh;

    // Threshold derivation and compare.
    always_comb begin
        shift  = (level_code == 4'd0) ? 4'd1 : level_code;
        thresh = CNT_W'(DEPTH) >> shift;
        below  = (count < thresh);
    end
endmodule

// File: rtl/afe_irq_status.sv
`timescale 1ns/1ps
// Module: status bits that set on a true condition and clear when 1 is written,
// plus the masked interrupt output. A held condition sets its bit again next cycle.
module afe_irq_status #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] cond,
    input  logic [NB-1:0] clr,
    input  logic [NB-1:0] mask,
    input  logic          int_en,
    output logic [NB-1:0] status,
    output logic          irq
);
    // Status latch with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | cond;
    end

    // Interrupt combine.
    assign irq = int_en && |(status & mask);

    for (genvar i = 0; i < NB; i++) begin : g_chk
        a_r8_cond_sets: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> status[i]);
        a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !cond[i]) |=> !status[i]);
    end
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

// File: rtl/audio_txfifo_regs.sv
`timescale 1ns/1ps
// Module: top of the audio FIFO front-end. It decodes the register window, holds
// the configuration and mask words, and connects the FIFO, the threshold
// compare and the status logic. Assumes one write per cycle and combinational reads.
module audio_txfifo_regs
    import afe_pkg::*;
#(
    parameter int          DEPTH   = 2048,
    parameter logic [31:0] VERSION = 32'h0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr_en,
    input  logic [2:0]  bus_word_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        fifo_pop,
    output logic [31:0] fifo_rd_data,
    output logic        fifo_empty,
    output logic        tx_enable,
    output logic [7:0]  clk_ratio,
    output logic [5:0]  sample_res,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    cfg_word_t        cfg;
    logic [1:0]       mask;
    logic [1:0]       status;
    logic [1:0]       clr;
    logic [1:0]       cond;
    logic             push, full, below;
    logic [CNT_W-1:0] count;

    assign push = bus_wr_en && (bus_word_addr == W_PUSH);
    assign clr  = (bus_wr_en && bus_word_addr == W_STATUS) ? bus_wdata[1:0] : 2'b00;

    // Configuration and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg  <= '0;
            mask <= '0;
        end else if (bus_wr_en) begin
            if (bus_word_addr == W_CONFIG) cfg  <= cfg_word_t'(bus_wdata);
            if (bus_word_addr == W_MASK)   mask <= bus_wdata[1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        case (bus_word_addr)
            W_VERSION: bus_rdata = VERSION;
            W_CONFIG:  bus_rdata = 32'(cfg);
            W_MASK:    bus_rdata = {30'd0, mask};
            W_STATUS:  bus_rdata = {30'd0, status};
            default:   bus_rdata = 32'd0;
        endcase
    end

    assign tx_enable  = cfg.tx_en;
    assign clk_ratio  = cfg.ratio;
    assign sample_res = cfg.res;

    afe_tx_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (bus_wdata),
        .pop   (fifo_pop),
        .rdata (fifo_rd_data),
        .empty (fifo_empty),
        .full  (full),
        .count (count)
    );

    afe_level_thresh #(.DEPTH(DEPTH)) u_thresh (
        .level_code (cfg.level_code),
        .count      (count),
        .below      (below)
    );

    assign cond[ST_UNDER] = fifo_empty;
    assign cond[ST_LEVEL] = below;

    afe_irq_status #(.NB(2)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (cond),
        .clr    (clr),
        .mask   (mask),
        .int_en (cfg.int_en),
        .status (status),
        .irq    (irq)
    );

    a_r3_push_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_empty && !fifo_pop) |=> !fifo_empty);
    a_r5_other_chan_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_word_addr > W_PUSH && !fifo_pop) |=> $stable(count));
    a_r10_fields_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_word_addr == W_CONFIG) |=> (clk_ratio == $past(bus_wdata[15:8])));
endmodule

// File: tb/audio_txfifo_regs_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases followed by seeded random push/pop traffic,
// all compared with a reference queue and threshold function.
module audio_txfifo_regs_bench;
    localparam int          DEPTH = 16;
    localparam logic [31:0] VER   = 32'h00C0_FFEE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [2:0]  bus_word_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        fifo_pop = 1'b0;
    logic [31:0] fifo_rd_data;
    logic        fifo_empty, tx_enable, irq;
    logic [7:0]  clk_ratio;
    logic [5:0]  sample_res;

    int errors = 0;
    int checks = 0;
    logic [31:0] model_q[$];
    logic [3:0]  cur_code = 4'd0;

    always #2.5 clk = ~clk;

    audio_txfifo_regs #(.DEPTH(DEPTH), .VERSION(VER)) u_audio_txfifo_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_word_addr(bus_word_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_pop(fifo_pop),
        .fifo_rd_data(fifo_rd_data), .fifo_empty(fifo_empty), .tx_enable(tx_enable),
        .clk_ratio(clk_ratio), .sample_res(sample_res), .irq(irq)
    );

    function automatic int thresh(input logic [3:0] code);
        return DEPTH >> ((code == 4'd0) ? 1 : int'(code));
    endfunction

    function automatic logic [31:0] exp_status(input int fill, input logic [3:0] code);
        return {30'd0, (fill < thresh(code)), (fill == 0)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_word_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_word_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic push_word(input logic [31:0] d);
        wr(3'd4, d);
        if (model_q.size() < DEPTH) model_q.push_back(d);
    endtask

    task automatic pop_word();
        @(negedge clk);
        fifo_pop = 1'b1;
        @(negedge clk);
        fifo_pop = 1'b0;
        if (model_q.size() > 0) void'(model_q.pop_front());
    endtask

    task automatic check_status(input string req);
        logic [31:0] v;
        wr(3'd3, 32'h3);
        rd(3'd3, v);
        chk(req, v, exp_status(model_q.size(), cur_code));
        chk(req, {31'd0, fifo_empty}, {31'd0, model_q.size() == 0});
        if (model_q.size() > 0) chk(req, fifo_rd_data, model_q[0]);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(3'd1, v); chk("R1 config", v, 32'd0);
        rd(3'd2, v); chk("R1 mask", v, 32'd0);
        rd(3'd3, v); chk("R1 status", v, 32'd0);
        chk("R1 empty", {31'd0, fifo_empty}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register map
        rd(3'd0, v); chk("R2 version", v, VER);
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, v); chk("R2 version write ignored", v, VER);
        wr(3'd1, 32'hA5A5_5A5A);
        rd(3'd1, v); chk("R2 config readback", v, 32'hA5A5_5A5A);
        // R10 exported fields
        chk("R10 tx_enable", {31'd0, tx_enable}, 32'd0);
        chk("R10 clk_ratio", {24'd0, clk_ratio}, 32'h5A);
        chk("R10 sample_res", {26'd0, sample_res}, 32'h25);
        wr(3'd1, 32'h0000_0301);
        chk("R10 tx_enable set", {31'd0, tx_enable}, 32'd1);
        chk("R10 clk_ratio", {24'd0, clk_ratio}, 32'h03);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 mask width", v, 32'h3);
        rd(3'd4, v); chk("R2 data word reads 0", v, 32'd0);
        rd(3'd7, v); chk("R2 word 7 reads 0", v, 32'd0);

        // R7 R6 underrun and level on empty FIFO with code 0
        cur_code = 4'd0;
        wr(3'd1, 32'd0);
        check_status("R7 R6 empty");

        // R9 interrupt gating
        wr(3'd2, 32'h1);
        chk("R9 int disabled", {31'd0, irq}, 32'd0);
        wr(3'd1, 32'h2);
        chk("R9 int enabled underrun", {31'd0, irq}, 32'd1);
        wr(3'd2, 32'h0);
        chk("R9 masked off", {31'd0, irq}, 32'd0);

        // R5 other channel writes
        wr(3'd5, 32'h1); wr(3'd6, 32'h2); wr(3'd7, 32'h3);
        chk("R5 no push", {31'd0, fifo_empty}, 32'd1);

        // R11 pop while empty, then a push is still correct
        pop_word();
        chk("R11 still empty", {31'd0, fifo_empty}, 32'd1);
        push_word(32'hCAFE_0001);
        chk("R11 R3 head after empty pop", fifo_rd_data, 32'hCAFE_0001);

        // R3 R4 fill to full then overflow push
        for (int i = 1; i < DEPTH; i++) push_word(32'h1000_0000 + i);
        wr(3'd4, 32'hDEAD_BEEF);
        check_status("R4 full status");
        // R8 with level and underrun false, cleared bits stay 0
        wr(3'd2, 32'h3);
        chk("R8 R9 no irq when full", {31'd0, irq}, 32'd0);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R3 R4 order", fifo_rd_data, model_q[0]);
            pop_word();
        end
        chk("R4 drained", {31'd0, fifo_empty}, 32'd1);
        // R8 held condition sets the bit again
        wr(3'd3, 32'h3);
        rd(3'd3, v); chk("R8 reassert", v, 32'h3);

        // R6 threshold over codes
        for (int c = 0; c < 6; c++) begin
            cur_code = 4'(c);
            wr(3'd1, {4'd0, 4'(c), 24'd0});
            for (int f = 0; f <= DEPTH / 2 + 1; f++) begin
                if (f == thresh(cur_code) - 1 || f == thresh(cur_code) || f == 0)
                    check_status("R6 threshold");
                push_word(32'h2000_0000 + f);
            end
            while (model_q.size() > 0) pop_word();
        end

        // random traffic, R3 R6 R7 R8
        cur_code = 4'd2;
        wr(3'd1, {4'd0, 4'd2, 24'd0});
        for (int n = 0; n < 300; n++) begin
            int op;
            op = int'($urandom_range(0, 9));
            if (op < 5) push_word($urandom);
            else if (op < 9) pop_word();
            else wr(3'(5 + $urandom_range(0, 2)), $urandom);
            check_status("R3 R6 R7 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule